// File: doc/BRIEF.md
# MDIO Management Master

This block is a register-mapped master for the two-wire management bus used to reach external PHYs. Software programs a configuration register (clock divisor, preamble enable, clause mode), loads a data register, and then writes a command holding a 2-bit operation code, a 5-bit PHY address and a 5-bit register or device address. That write launches one serial frame on MDC/MDIO. The command is the only register with a side effect, and the write-data and read-data registers each carry a pending flag that software polls.

One register set serves both clause modes. The mode bit changes what the operation code means and which start code goes on the wire. An extended-clause access takes two commands. The first is an address cycle that sends the 16-bit register address held in the write-data register. The second is the actual read or write. When a read completes, the read-data register holds the 16 bits taken from the wire and a valid flag. That flag is set only when the PHY pulled the line low in the second turnaround bit.

Top module: `mdio_master`

## Requirements
- R1: Register decode uses byte offsets 0x00 command, 0x08 write data, 0x10 read data, 0x18 configuration and 0x20 enable. The command fields are op in bits [1:0], PHY address in [12:8] and register/device address in [20:16]. Write data and read data occupy bits [15:0]. Write pending is bit 31 of 0x08. Read pending is bit 31 and read valid is bit 30 of 0x10. Configuration holds the divisor in [7:0], preamble enable in bit 12 and clause-45 mode in bit 24, and resets to 0x0000_1005. Enable is bit 0 of 0x20 and resets to 0. The command offset reads as zero.
- R2: While the enable bit is 0, a command write starts no frame, MDC stays low and neither pending flag sets.
- R3: In clause-22 mode, op 0 sends a write and op 1 sends a read. The frame is start 01, wire opcode (01 write, 10 read), PHY address, register address, turnaround and 16 data bits, each field sent most significant bit first.
- R4: In clause-45 mode, op 0 sends an address cycle (wire opcode 00), op 1 a write (01) and op 3 a read (10), all with start code 00. Address cycles and writes send the write-data register as the 16 data bits.
- R5: Op 2 and op 3 in clause-22 mode, and op 2 in clause-45 mode, start nothing.
- R6: With preamble enabled, every frame is led by 32 ones. With it disabled, the frame begins directly with the start code, so a frame has 64 or 32 MDC rising edges.
- R7: Writes and address cycles drive turnaround as 10 and keep MDIO driven for the whole frame. Reads drive MDIO only up to the register address, then release it. On a read, read data takes the 16 bits sampled after turnaround, and read valid is 1 only if MDIO was low at the second turnaround bit.
- R8: Write pending rises on the edge that accepts a write or address command, and read pending rises on the edge that accepts a read (clearing read valid). Each flag falls on the edge of the frame's last MDC falling edge.
- R9: A command written while either pending flag is 1 is ignored. This includes a write that lands on the very edge where the frame completes. A write one cycle later is accepted.
- R10: MDC idles low. Each half period lasts divisor system clocks, with a divisor of 0 acting as 1. MDIO changes only together with MDC falling, and the master samples MDIO on MDC rising.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
Frame completion and command acceptance can meet on the same clock edge: the edge that drops pending is also the edge on which a newly written command is judged. The bench counts MDC rising edges at the port until the last bit of a frame. It then places the command strobe so that it is sampled exactly on the final falling edge, and a second time one cycle later. The first must leave the pending flag clear and produce no further MDC edges. The second must raise pending and produce a complete new frame.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int OFS_CMD  = 'h00;
    localparam int OFS_WDAT = 'h08;
    localparam int OFS_RDAT = 'h10;
    localparam int OFS_CFG  = 'h18;
    localparam int OFS_EN   = 'h20;

    localparam logic [1:0] WOP_ADDR  = 2'b00;
    localparam logic [1:0] WOP_WRITE = 2'b01;
    localparam logic [1:0] WOP_READ  = 2'b10;

    typedef struct packed {
        logic       ok;
        logic       is_read;
        logic [1:0] wop;
    } op_map_t;

    // Translate the software opcode into a wire opcode for the active clause mode
    function automatic op_map_t map_op(input logic c45, input logic [1:0] op);
        op_map_t m;
        m = '{ok: 1'b0, is_read: 1'b0, wop: WOP_ADDR};
        if (!c45) begin
            if (op == 2'd0) m = '{ok: 1'b1, is_read: 1'b0, wop: WOP_WRITE};
            if (op == 2'd1) m = '{ok: 1'b1, is_read: 1'b1, wop: WOP_READ};
        end else begin
            if (op == 2'd0) m = '{ok: 1'b1, is_read: 1'b0, wop: WOP_ADDR};
            if (op == 2'd1) m = '{ok: 1'b1, is_read: 1'b0, wop: WOP_WRITE};
            if (op == 2'd3) m = '{ok: 1'b1, is_read: 1'b1, wop: WOP_READ};
        end
        return m;
    endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise_tick,
    output logic             fall_tick
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             mdc;
    } gen_t;

    gen_t q, d;
    logic [DIV_W-1:0] half;
    logic             tick;

    always_comb begin
        half = (div == '0) ? DIV_W'(1) : div;
        tick = run && (q.cnt == half - 1'b1);
        d    = q;
        if (!run) begin
            d.cnt = '0;
            d.mdc = 1'b0;
        end else if (tick) begin
            d.cnt = '0;
            d.mdc = ~q.mdc;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mdc       = q.mdc;
    assign rise_tick = tick && !q.mdc;
    assign fall_tick = tick && q.mdc;

endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
    import mdio_pkg::*;
#(
    parameter int PRE_LEN = 32,
    parameter int AW      = 5,
    parameter int DW      = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          pre_en,
    input  logic          c45,
    input  logic [1:0]    wop,
    input  logic [AW-1:0] phy,
    input  logic [AW-1:0] regad,
    input  logic [DW-1:0] wdata,
    input  logic          rise_tick,
    input  logic          fall_tick,
    input  logic          mdio_i,
    output logic          busy,
    output logic          done,
    output logic          is_read,
    output logic [DW-1:0] rd_data,
    output logic          rd_ok,
    output logic          mdio_o,
    output logic          mdio_oe
);

    localparam int FL     = 6 + 2 * AW + DW;
    localparam int TA_POS = 4 + 2 * AW;
    localparam int CW     = $clog2(((PRE_LEN > FL) ? PRE_LEN : FL) + 1);

    typedef struct packed {
        logic          busy;
        logic          rd;
        logic          ta_ok;
        logic [CW-1:0] pre_left;
        logic [CW-1:0] pos;
        logic [FL-1:0] frame;
        logic [DW-1:0] rdat;
    } eng_t;

    eng_t q, d;
    logic in_pre;
    logic last_fall;
    logic rd_start;

    always_comb begin
        in_pre    = (q.pre_left != '0);
        last_fall = q.busy && fall_tick && !in_pre && (q.pos == CW'(FL - 1));
        rd_start  = (wop == WOP_READ);
        d         = q;
        if (!q.busy) begin
            if (start) begin
                d.busy     = 1'b1;
                d.rd       = rd_start;
                d.ta_ok    = 1'b0;
                d.pos      = '0;
                d.pre_left = pre_en ? CW'(PRE_LEN) : '0;
                d.rdat     = '0;
                d.frame    = {(c45 ? 2'b00 : 2'b01), wop, phy, regad,
                              (rd_start ? 2'b00 : 2'b10),
                              (rd_start ? {DW{1'b0}} : wdata)};
            end
        end else if (rise_tick) begin
            // sample on the rising edge, only in the released part of a read
            if (!in_pre && q.rd) begin
                if (q.pos == CW'(TA_POS + 1))     d.ta_ok = ~mdio_i;
                else if (q.pos > CW'(TA_POS + 1)) d.rdat  = {q.rdat[DW-2:0], mdio_i};
            end
        end else if (fall_tick) begin
            if (in_pre) begin
                d.pre_left = q.pre_left - 1'b1;
            end else if (last_fall) begin
                d.busy = 1'b0;
            end else begin
                d.pos   = q.pos + 1'b1;
                d.frame = {q.frame[FL-2:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy    = q.busy;
    assign done    = last_fall;
    assign is_read = q.rd;
    assign rd_data = q.rdat;
    assign rd_ok   = q.ta_ok;
    assign mdio_o  = (!q.busy || in_pre) ? 1'b1 : q.frame[FL-1];
    assign mdio_oe = q.busy && !(q.rd && !in_pre && (q.pos >= CW'(TA_POS)));

endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int RA_W    = 6,
    parameter int DIV_W   = 8,
    parameter int DIV_RST = 5,
    parameter int PRE_LEN = 32,
    parameter int PHY_AW  = 5,
    parameter int DATA_W  = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_we,
    input  logic [RA_W-1:0] reg_addr,
    input  logic [31:0]     reg_wdata,
    output logic [31:0]     reg_rdata,
    output logic            mdc,
    output logic            mdio_o,
    output logic            mdio_oe,
    input  logic            mdio_i
);

    localparam int PHY_LSB = 8;
    localparam int REG_LSB = 16;
    localparam int PRE_BIT = 12;
    localparam int C45_BIT = 24;
    localparam int PND_BIT = 31;
    localparam int VAL_BIT = 30;

    typedef struct packed {
        logic [DATA_W-1:0] wdat;
        logic              wr_pend;
        logic [DATA_W-1:0] rdat;
        logic              rd_pend;
        logic              rd_val;
        logic [DIV_W-1:0]  div;
        logic              pre_en;
        logic              c45;
        logic              en;
    } regs_t;

    regs_t q, d;
    op_map_t opm;
    logic cmd_wr, wdat_wr, cfg_wr, en_wr;
    logic start, pend_w, en_w, rd_val_w;
    logic rise_tick, fall_tick;
    logic eng_busy, eng_done, eng_is_read, eng_rd_ok;
    logic [DATA_W-1:0] eng_rd_data;
    logic unused_wdata;

    assign unused_wdata = ^reg_wdata;

    always_comb begin
        cmd_wr  = reg_we && (reg_addr == RA_W'(OFS_CMD));
        wdat_wr = reg_we && (reg_addr == RA_W'(OFS_WDAT));
        cfg_wr  = reg_we && (reg_addr == RA_W'(OFS_CFG));
        en_wr   = reg_we && (reg_addr == RA_W'(OFS_EN));
        opm     = map_op(q.c45, reg_wdata[1:0]);
        pend_w  = q.wr_pend || q.rd_pend;
        start   = cmd_wr && q.en && !pend_w && opm.ok;

        d = q;
        if (wdat_wr) d.wdat = reg_wdata[DATA_W-1:0];
        if (cfg_wr) begin
            d.div    = reg_wdata[DIV_W-1:0];
            d.pre_en = reg_wdata[PRE_BIT];
            d.c45    = reg_wdata[C45_BIT];
        end
        if (en_wr) d.en = reg_wdata[0];
        if (start) begin
            if (opm.is_read) begin
                d.rd_pend = 1'b1;
                d.rd_val  = 1'b0;
            end else begin
                d.wr_pend = 1'b1;
            end
        end
        if (eng_done) begin
            if (eng_is_read) begin
                d.rd_pend = 1'b0;
                d.rdat    = eng_rd_data;
                d.rd_val  = eng_rd_ok;
            end else begin
                d.wr_pend = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.div    <= DIV_W'(DIV_RST);
            q.pre_en <= 1'b1;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == RA_W'(OFS_WDAT)) begin
            reg_rdata[DATA_W-1:0] = q.wdat;
            reg_rdata[PND_BIT]    = q.wr_pend;
        end else if (reg_addr == RA_W'(OFS_RDAT)) begin
            reg_rdata[DATA_W-1:0] = q.rdat;
            reg_rdata[PND_BIT]    = q.rd_pend;
            reg_rdata[VAL_BIT]    = q.rd_val;
        end else if (reg_addr == RA_W'(OFS_CFG)) begin
            reg_rdata[DIV_W-1:0] = q.div;
            reg_rdata[PRE_BIT]   = q.pre_en;
            reg_rdata[C45_BIT]   = q.c45;
        end else if (reg_addr == RA_W'(OFS_EN)) begin
            reg_rdata[0] = q.en;
        end
    end

    assign en_w     = q.en;
    assign rd_val_w = q.rd_val;

    mdio_mdc_gen #(.DIV_W(DIV_W)) u_mdc (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (eng_busy),
        .div       (q.div),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_frame_eng #(.PRE_LEN(PRE_LEN), .AW(PHY_AW), .DW(DATA_W)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .pre_en    (q.pre_en),
        .c45       (q.c45),
        .wop       (opm.wop),
        .phy       (reg_wdata[PHY_LSB +: PHY_AW]),
        .regad     (reg_wdata[REG_LSB +: PHY_AW]),
        .wdata     (q.wdat),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .mdio_i    (mdio_i),
        .busy      (eng_busy),
        .done      (eng_done),
        .is_read   (eng_is_read),
        .rd_data   (eng_rd_data),
        .rd_ok     (eng_rd_ok),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe)
    );

endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
    input logic clk,
    input logic rst_n,
    input logic mdc,
    input logic mdio_oe,
    input logic busy,
    input logic is_rd,
    input logic done,
    input logic en,
    input logic pend,
    input logic cmd_wr,
    input logic rd_val
);

    // R10
    mdc_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);

    // R7
    write_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !is_rd) |-> mdio_oe);

    // R8
    pend_tracks_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend == busy);

    // R7
    valid_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_val) |-> $past(done && is_rd));

    // R2
    disabled_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !busy) |=> !busy);

    // R9
    busy_cmd_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_wr && !done) |=> busy);

endmodule

bind mdio_master mdio_master_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .mdc     (mdc),
    .mdio_oe (mdio_oe),
    .busy    (eng_busy),
    .is_rd   (eng_is_read),
    .done    (eng_done),
    .en      (en_w),
    .pend    (pend_w),
    .cmd_wr  (cmd_wr),
    .rd_val  (rd_val_w)
);

// File: tb/mdio_master_tb_top.sv
module mdio_master_tb_top;

    typedef struct packed {
        logic        c45;
        logic        pre;
        logic [1:0]  op;
        logic [4:0]  phy;
        logic [4:0]  dev;
        logic [15:0] wd;
        logic [15:0] rsp;
        logic        ta;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{1'b0, 1'b1, 2'd0, 5'd5,  5'd3,  16'hA5C3, 16'h0000, 1'b1},
        '{1'b0, 1'b1, 2'd1, 5'd31, 5'd2,  16'h0000, 16'h1234, 1'b1},
        '{1'b1, 1'b1, 2'd0, 5'd3,  5'd1,  16'hBEEF, 16'h0000, 1'b1},
        '{1'b1, 1'b0, 2'd1, 5'd3,  5'd1,  16'h0F0F, 16'h0000, 1'b1},
        '{1'b1, 1'b1, 2'd3, 5'd7,  5'd30, 16'h0000, 16'hCAFE, 1'b1},
        '{1'b0, 1'b0, 2'd1, 5'd9,  5'd4,  16'h0000, 16'h5555, 1'b0},
        '{1'b0, 1'b1, 2'd2, 5'd1,  5'd1,  16'h1111, 16'h0000, 1'b1},
        '{1'b1, 1'b0, 2'd2, 5'd1,  5'd1,  16'h2222, 16'h0000, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    int cyc = 0;
    int rise_total = 0;
    int last_rise_cyc = 0;
    int last_per = 0;
    int base = 0;
    int pre_len = 32;
    bit rsp_rd = 0;
    logic [15:0] rsp_data = '0;
    bit rsp_ta = 1;
    logic [63:0] cap_o = '0;
    logic [63:0] cap_oe = '0;

    always #5 clk = ~clk;

    mdio_master dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .mdc       (mdc),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .mdio_i    (mdio_i)
    );

    always @(posedge clk) cyc++;

    // PHY-side capture on MDC rising edges
    always @(posedge mdc) begin
        cap_o         <= {cap_o[62:0], mdio_o};
        cap_oe        <= {cap_oe[62:0], mdio_oe};
        rise_total    <= rise_total + 1;
        last_per      <= cyc - last_rise_cyc;
        last_rise_cyc <= cyc;
    end

    // PHY-side response launched after MDC falls
    always @(negedge mdc) begin
        int p;
        p = (rise_total - base) - pre_len;
        if (rsp_rd && p == 15)                 mdio_i <= rsp_ta ? 1'b0 : 1'b1;
        else if (rsp_rd && p >= 16 && p <= 31) mdio_i <= rsp_data[31 - p];
        else                                   mdio_i <= 1'b1;
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [5:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_we    = 1'b1;
        reg_addr  = a;
        reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [5:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    function automatic logic [31:0] cmd_word(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] dev);
        return {11'd0, dev, 3'd0, phy, 6'd0, op};
    endfunction

    function automatic bit exp_start(input logic c45, input logic [1:0] op);
        return c45 ? (op != 2'd2) : (op <= 2'd1);
    endfunction

    function automatic bit exp_read(input logic c45, input logic [1:0] op);
        return c45 ? (op == 2'd3) : (op == 2'd1);
    endfunction

    function automatic logic [31:0] exp_frame(input vec_t v);
        logic [1:0] w;
        bit rd;
        rd = exp_read(v.c45, v.op);
        if (rd)                        w = 2'b10;
        else if (v.c45 && v.op == 2'd0) w = 2'b00;
        else                           w = 2'b01;
        return {(v.c45 ? 2'b00 : 2'b01), w, v.phy, v.dev,
                (rd ? 2'b00 : 2'b10), (rd ? 16'h0000 : v.wd)};
    endfunction

    task automatic wait_idle();
        logic [31:0] a, b;
        for (int i = 0; i < 4000; i++) begin
            reg_read(6'h08, a);
            reg_read(6'h10, b);
            if (!a[31] && !b[31]) break;
        end
    endtask

    task automatic arm(input vec_t v);
        base     = rise_total;
        pre_len  = v.pre ? 32 : 0;
        rsp_rd   = exp_read(v.c45, v.op);
        rsp_data = v.rsp;
        rsp_ta   = v.ta;
    endtask

    task automatic run_vec(input vec_t v, input int div);
        logic [31:0] r;
        logic [31:0] ef;
        int nr;
        reg_write(6'h18, {7'd0, v.c45, 11'd0, v.pre, 4'd0, 8'(div)});
        reg_write(6'h08, {16'd0, v.wd});
        arm(v);
        reg_write(6'h00, cmd_word(v.op, v.phy, v.dev));
        ef = exp_frame(v);
        if (!exp_start(v.c45, v.op)) begin
            repeat (100) @(negedge clk);
            reg_read(6'h08, r);
            check(!r[31], "R5 ignored op sets no write pending", r[31], 0);
            reg_read(6'h10, r);
            check(!r[31], "R5 ignored op sets no read pending", r[31], 0);
            check(rise_total == base, "R5 ignored op makes no MDC edge", rise_total - base, 0);
            return;
        end
        reg_read(exp_read(v.c45, v.op) ? 6'h10 : 6'h08, r);
        check(r[31], "R8 pending set after command", r[31], 1);
        wait_idle();
        nr = rise_total - base;
        check(nr == pre_len + 32, "R6 MDC rising edge count", nr, pre_len + 32);
        if (v.pre)
            check(cap_o[63:32] == 32'hFFFF_FFFF, "R6 preamble all ones", cap_o[63:32], 32'hFFFF_FFFF);
        if (exp_read(v.c45, v.op)) begin
            check(cap_o[31:18] == ef[31:18], v.c45 ? "R4 read header" : "R3 read header", cap_o[31:18], ef[31:18]);
            check(cap_oe[31:18] == 14'h3FFF && cap_oe[17:0] == 18'h0, "R7 read releases at turnaround",
                  cap_oe[31:0], 32'hFFFC_0000);
            reg_read(6'h10, r);
            check(r[30] == v.ta, "R7 read valid flag", r[30], v.ta);
            if (v.ta) check(r[15:0] == v.rsp, "R7 read data captured", r[15:0], v.rsp);
        end else begin
            check(cap_o[31:0] == ef, v.c45 ? "R4 frame bits" : "R3 frame bits", cap_o[31:0], ef);
            check(cap_oe[31:0] == 32'hFFFF_FFFF, "R7 write keeps MDIO driven", cap_oe[31:0], 32'hFFFF_FFFF);
        end
        check(last_per == 2 * ((div == 0) ? 1 : div), "R10 MDC period", last_per, 2 * ((div == 0) ? 1 : div));
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        vec_t v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        reg_read(6'h18, r);
        check(r == 32'h0000_1005, "R1 config reset value", r, 32'h0000_1005);
        reg_read(6'h20, r);
        check(r == 32'h0, "R1 enable reset value", r, 0);
        reg_read(6'h10, r);
        check(r == 32'h0, "R1 read-data reset value", r, 0);
        reg_read(6'h00, r);
        check(r == 32'h0, "R1 command offset reads zero", r, 0);
        check(mdc == 1'b0 && mdio_oe == 1'b0, "R10 MDC idle low and MDIO released", {mdc, mdio_oe}, 0);

        // R2 disabled controller
        reg_write(6'h18, 32'h0000_1002);
        base = rise_total;
        reg_write(6'h00, cmd_word(2'd0, 5'd1, 5'd1));
        repeat (60) @(negedge clk);
        reg_read(6'h08, r);
        check(!r[31], "R2 no pending while disabled", r[31], 0);
        check(rise_total == base, "R2 no MDC while disabled", rise_total - base, 0);

        reg_write(6'h20, 32'h1);
        reg_read(6'h20, r);
        check(r[0], "R1 enable bit readback", r[0], 1);

        for (int i = 0; i < 8; i++) run_vec(VECS[i], 2);

        // R10 divisor variants
        v = '{1'b0, 1'b0, 2'd0, 5'd2, 5'd6, 16'h3C3C, 16'h0, 1'b1};
        run_vec(v, 0);
        run_vec(v, 3);

        // R9 command while busy is ignored
        v = '{1'b0, 1'b1, 2'd0, 5'd5, 5'd3, 16'h1111, 16'h0, 1'b1};
        reg_write(6'h18, 32'h0000_1002);
        reg_write(6'h08, 32'h0000_1111);
        arm(v);
        reg_write(6'h00, cmd_word(2'd0, 5'd5, 5'd3));
        repeat (40) @(negedge clk);
        reg_write(6'h00, cmd_word(2'd1, 5'd9, 5'd9));
        wait_idle();
        check(rise_total - base == 64, "R9 busy command adds no frame", rise_total - base, 64);
        check(cap_o[31:0] == exp_frame(v), "R9 frame unchanged by busy command", cap_o[31:0], exp_frame(v));
        reg_read(6'h10, r);
        check(!r[31], "R9 busy read command leaves read pending clear", r[31], 0);

        // R9 command landing on the completion edge, then one cycle later
        v = '{1'b0, 1'b0, 2'd0, 5'd4, 5'd8, 16'h0000, 16'h0, 1'b1};
        reg_write(6'h18, 32'h0000_0002);
        arm(v);
        reg_write(6'h00, cmd_word(2'd0, 5'd4, 5'd8));
        for (int i = 0; i < 5000 && (rise_total - base) != 32; i++) @(negedge clk);
        reg_write(6'h00, cmd_word(2'd0, 5'd4, 5'd8));
        reg_read(6'h08, r);
        check(!r[31], "R9 command on completion edge ignored", r[31], 0);
        repeat (50) @(negedge clk);
        check(rise_total - base == 32, "R9 no frame after completion-edge command", rise_total - base, 32);

        arm(v);
        reg_write(6'h00, cmd_word(2'd0, 5'd4, 5'd8));
        for (int i = 0; i < 5000 && (rise_total - base) != 32; i++) @(negedge clk);
        @(negedge clk);
        reg_write(6'h00, cmd_word(2'd0, 5'd4, 5'd8));
        reg_read(6'h08, r);
        check(r[31], "R9 command one cycle after completion accepted", r[31], 1);
        wait_idle();
        check(rise_total - base == 64, "R9 accepted command runs a full frame", rise_total - base, 64);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule